// File: doc/BRIEF.md
# Dual-Mode Serial Baud Generator

This block turns a system clock into the 16x oversampling strobe used by an asynchronous serial port. It has two ways of producing that strobe, chosen by a single mode input. The integer divider counts a whole number of clocks between strobes and suits slow bit rates. The fractional accumulator adds a 16-bit increment into a 16-bit phase register on every clock and emits a strobe on each carry out of the top bit. That gives fine frequency resolution at high bit rates, with jitter of at most one clock.

For the divider, the rate value is `f_clk / (16 * baud)`. For the accumulator, it is `baud * 16 * 65536 / f_clk`; this mode is meant for rates above 19200 baud. The fastest usable rate is `f_clk / 16`, where a strobe falls on every clock. A run input gates the whole generator.

Any change of the rate value or of the mode while running, and any rising edge of run, restarts the active engine from zero. The first strobe after a restart therefore falls on a known cycle. The block has no data stream, so every pin is a plain level or pulse without a handshake.

Top module: `baud_gen_top`

## Requirements
- R1: With mode_sel = 0 (divider) and rate_val = N with N >= 2, tick_o pulses high for exactly one cycle every N clocks, and is never high on two consecutive cycles.
- R2: With mode_sel = 0 and rate_val equal to 0 or 1, tick_o is high on every clock while running.
- R3: With mode_sel = 1 (accumulator), each clock adds rate_val into a 16-bit phase register and tick_o is high in the cycle after a carry out of bit 15. Over the first W cycles after a restart, exactly floor(W * rate_val / 65536) ticks appear.
- R4: With mode_sel = 1 and rate_val = 0, tick_o never pulses.
- R5: mode_sel = 1 selects the accumulator and mode_sel = 0 selects the divider. Only the selected engine may produce ticks.
- R6: While run_en is low, tick_o stays low. Dropping run_en forces tick_o low from the next cycle.
- R7: A rising edge of run_en, or a change of rate_val or mode_sel while run_en is high, restarts the generator. tick_o is low in the cycle that follows the restart edge. The first tick then comes N cycles after that edge in divider mode (1 when N <= 1), or ceil(65536 / rate_val) cycles after it in accumulator mode.
- R8: While rst_n is low, tick_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generator enable; a rising edge restarts it |
| mode_sel | input | 1 | 0 = integer divider, 1 = fractional accumulator |
| rate_val | input | 16 | Divisor (divider mode) or phase increment (accumulator mode) |
| tick_o | output | 1 | One-cycle 16x oversampling strobe |

## Verification
All results are registered, so tick_o reflects the clock edge just before it. A stimulus applied before restart edge E0 gives a quiet tick_o after E0. The first strobe is expected after edge N (divider) or after edge ceil(65536/rate_val) (accumulator).

The bench changes inputs on falling edges and samples tick_o on the falling edge after each rising edge. Each sample is indexed by the number of edges since E0, and that index is compared with the computed first-tick cycle. The bench also counts ticks over a fixed window and compares the count with the closed-form value for that window.

// File: rtl/baud_gen_pkg.sv
`timescale 1ns/1ps
package baud_gen_pkg;
  parameter int unsigned BG_RATE_W = 16;

  typedef enum logic {
    MODE_DIV = 1'b0,
    MODE_ACC = 1'b1
  } bg_mode_e;
endpackage

// File: rtl/baud_gen_ctrl.sv
`timescale 1ns/1ps
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int unsigned RATE_W = BG_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              mode_sel,
  input  logic [RATE_W-1:0] rate_val,
  output logic              restart,
  output bg_mode_e          mode_q
);
  logic              run_q;
  logic [RATE_W-1:0] rate_q;

  // restart pulse: fresh enable, or a setting changed under a running generator
  assign restart = run_en & (~run_q | (rate_val != rate_q) | (mode_sel != logic'(mode_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rate_q <= '0;
      mode_q <= MODE_DIV;
    end else begin
      run_q  <= run_en;
      rate_q <= rate_val;
      mode_q <= bg_mode_e'(mode_sel);
    end
  end

  AST_SETTINGS_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $stable(rate_val) && $stable(mode_sel) && $past(run_en)) |-> !restart); // R7
endmodule

// File: rtl/baud_gen_div.sv
`timescale 1ns/1ps
module baud_gen_div #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [RATE_W-1:0] limit,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] last_cnt;

  // 0 and 1 both mean a tick per clock
  assign last_cnt = (limit <= RATE_W'(1)) ? '0 : limit - RATE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (!en || restart) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= last_cnt) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + RATE_W'(1);
      tick_o <= 1'b0;
    end
  end

  AST_DIV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && tick_o && limit > RATE_W'(1)) |=> !tick_o); // R1
  AST_DIV_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && limit <= RATE_W'(1)) |=> tick_o); // R2
endmodule

// File: rtl/baud_gen_acc.sv
`timescale 1ns/1ps
module baud_gen_acc #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [RATE_W-1:0] incr,
  output logic              tick_o
);
  logic [RATE_W-1:0] phase;
  logic [RATE_W:0]   sum;

  assign sum = {1'b0, phase} + {1'b0, incr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      tick_o <= 1'b0;
    end else if (!en || restart) begin
      phase  <= '0;
      tick_o <= 1'b0;
    end else begin
      phase  <= sum[RATE_W-1:0];
      tick_o <= sum[RATE_W];
    end
  end

  AST_ACC_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && incr == '0) |=> !tick_o); // R4
endmodule

// File: rtl/baud_gen_top.sv
`timescale 1ns/1ps
module baud_gen_top
  import baud_gen_pkg::*;
#(
  parameter int unsigned RATE_W = BG_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              mode_sel,
  input  logic [RATE_W-1:0] rate_val,
  output logic              tick_o
);
  logic     restart;
  bg_mode_e mode_q;
  logic     div_en, acc_en;
  logic     div_tick, acc_tick;

  baud_gen_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_sel(mode_sel),
    .rate_val(rate_val), .restart(restart), .mode_q(mode_q)
  );

  // only the selected engine runs; the other is held cleared
  assign div_en = run_en & (bg_mode_e'(mode_sel) == MODE_DIV);
  assign acc_en = run_en & (bg_mode_e'(mode_sel) == MODE_ACC);

  baud_gen_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(div_en), .restart(restart),
    .limit(rate_val), .tick_o(div_tick)
  );

  baud_gen_acc #(.RATE_W(RATE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .restart(restart),
    .incr(rate_val), .tick_o(acc_tick)
  );

  assign tick_o = (mode_q == MODE_ACC) ? acc_tick : div_tick;

  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_tick, acc_tick})); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !tick_o); // R6
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_o); // R7
  always_comb begin
    if (!rst_n) AST_RESET_LOW: assert (!div_tick && !acc_tick); // R8
  end
endmodule

// File: tb/sim_baud_gen_top.sv
`timescale 1ns/1ps
module sim_baud_gen_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        mode_sel = 1'b0;
  logic [15:0] rate_val = 16'd0;
  logic        tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_gen_top u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_sel(mode_sel),
    .rate_val(rate_val), .tick_o(tick_o)
  );

  localparam int NV = 13;
  localparam int V_MODE [0:NV-1] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam int V_VAL  [0:NV-1] = '{4, 5, 16, 300, 1, 0,
                                     32768, 4096, 21845, 256, 65535, 19, 0};
  localparam int V_WIN  [0:NV-1] = '{400, 400, 800, 1000, 200, 200,
                                     400, 800, 600, 1000, 300, 4000, 500};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_count(input int m, input int v, input int w);
    longint n;
    if (m == 0) begin
      n = (v <= 1) ? 1 : v;
      return w / n;
    end
    return (longint'(w) * v) >> 16;
  endfunction

  function automatic int exp_first(input int m, input int v, input int w);
    int f;
    if (m == 0) f = (v <= 1) ? 1 : v;
    else if (v == 0) f = 0;
    else f = (65536 + v - 1) / v;
    return (f > w) ? 0 : f;
  endfunction

  // call at a falling edge right after driving the restart stimulus
  task automatic measure(input int w, output int q0, output int cnt, output int first);
    cnt = 0; first = 0;
    @(posedge clk); @(negedge clk);
    q0 = tick_o;
    for (int k = 1; k <= w; k++) begin
      @(posedge clk); @(negedge clk);
      if (tick_o) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
  endtask

  initial begin
    int q0, cnt, first, idle;
    string tag;
    repeat (3) @(negedge clk);
    chk(tick_o == 1'b0, "R8 tick low in reset", tick_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_en = 1'b0; mode_sel = V_MODE[i][0]; rate_val = V_VAL[i][15:0];
      idle = 0;
      repeat (3) begin @(negedge clk); idle += tick_o; end
      chk(idle == 0, "R6 idle before run", idle, 0);
      if (V_MODE[i] == 0) tag = (V_VAL[i] <= 1) ? "R2/R5 divider" : "R1/R5 divider";
      else tag = (V_VAL[i] == 0) ? "R4/R5 accumulator" : "R3/R5 accumulator";
      run_en = 1'b1;
      measure(V_WIN[i], q0, cnt, first);
      chk(q0 == 0, "R7 quiet after restart", q0, 0);
      chk(cnt == exp_count(V_MODE[i], V_VAL[i], V_WIN[i]), {tag, " count"},
          cnt, exp_count(V_MODE[i], V_VAL[i], V_WIN[i]));
      chk(first == exp_first(V_MODE[i], V_VAL[i], V_WIN[i]), {"R7 ", tag, " first tick"},
          first, exp_first(V_MODE[i], V_VAL[i], V_WIN[i]));
    end

    // R6: stopped generator at full rate setting, then stop while running
    run_en = 1'b0; mode_sel = 1'b0; rate_val = 16'd1;
    idle = 0;
    repeat (50) begin @(negedge clk); idle += tick_o; end
    chk(idle == 0, "R6 no ticks while stopped", idle, 0);
    run_en = 1'b1;
    repeat (10) @(negedge clk);
    run_en = 1'b0;
    idle = 0;
    repeat (40) begin @(negedge clk); idle += tick_o; end
    chk(idle == 0, "R6 ticks stop after run drop", idle, 0);

    // R7: value change while running in divider mode
    run_en = 1'b1; rate_val = 16'd8;
    repeat (21) @(negedge clk);
    rate_val = 16'd3;
    measure(30, q0, cnt, first);
    chk(q0 == 0, "R7 quiet after value change", q0, 0);
    chk(first == 3, "R7 first tick after value change", first, 3);
    chk(cnt == 10, "R1 count after value change", cnt, 10);

    // R5/R7: mode change while running
    mode_sel = 1'b1; rate_val = 16'h4000;
    measure(40, q0, cnt, first);
    chk(q0 == 0, "R7 quiet after mode change", q0, 0);
    chk(first == 4, "R5 first tick after mode change", first, 4);
    chk(cnt == 10, "R3 count after mode change", cnt, 10);

    // R7: one-cycle run drop restarts the accumulator phase
    repeat (3) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
    measure(12, q0, cnt, first);
    chk(first == 4, "R7 first tick after run re-assert", first, 4);
    chk(cnt == 3, "R3 count after run re-assert", cnt, 3);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule